// File: doc/BRIEF.md
# Byte-Framed Bus Command Engine

This block turns framed command packets, received one byte at a time over a syn/ack byte link, into single-word accesses on a simple core bus. Three commands are supported: pulse the core's active-low reset, read one 32-bit word, or write one 32-bit word at a 16-bit address. After each command it sends a framed reply over a second syn/ack byte link. The reply carries a status code and, for a successful read, the data word.

Received bytes go into a small buffer that the command parser drains. While the engine is busy with a bus access or a reply, the parser stops draining the buffer. Once the buffer is full, the receive link is held off by withholding the acknowledge. Malformed traffic is handled as follows: bytes outside a frame are skipped, an unknown opcode is reported at once, and a frame with a wrong closing byte is answered with an error status.

Top module: `frame_cmd_engine`

## Requirements
- R1: After reset, rx_ack, tx_syn, core_cs and core_we are 0 and core_rst_n is 1.
- R2: Each byte offered with rx_syn high gets exactly one rx_ack pulse, one cycle long, in the cycle after the byte is stored. No further byte is taken until rx_syn has returned low.
- R3: The receive buffer holds up to DEPTH (default 8) bytes. While it is full, rx_ack stays low and the offered byte waits. The byte is taken once the parser frees a slot.
- R4: The frame 0x55, 0x01, 0xAA drives core_rst_n low for exactly RST_CYCLES (default 4) cycles, makes no bus access, and is answered with 0xAA, 0x7D, 0x55.
- R5: The frame 0x55, 0x10, addr[15:8], addr[7:0], 0xAA makes one single-cycle access with core_cs=1, core_we=0 and core_addr=addr. It is answered with 0xAA, 0x7F, then the four read-data bytes starting with the most significant, then 0x55.
- R6: The frame 0x55, 0x11, addr[15:8], addr[7:0], data[31:24], data[23:16], data[15:8], data[7:0], 0xAA makes one single-cycle access with core_cs=1, core_we=1, core_addr=addr and core_wdata=data. It is answered with 0xAA, 0x7E, 0x55.
- R7: If core_err is high in the access cycle, the reply to a read or a write is 0xAA, 0xFD, 0x55, with no data bytes.
- R8: An opcode byte other than 0x01, 0x10 or 0x11 is answered at once with 0xAA, 0xFE, 0x55 and causes no bus access. The parser then skips bytes until the next 0x55.
- R9: A read or write frame whose closing byte is not 0xAA causes no bus access and is answered with 0xAA, 0xFD, 0x55.
- R10: Bytes received while a start byte 0x55 is awaited, and which are not 0x55, are discarded. They cause no reply and no bus access.
- R11: Each reply byte is held on tx_data with tx_syn high until tx_ack arrives, however late the ack is. The next byte is presented only after tx_ack has returned low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_syn | input | 1 | Incoming byte valid strobe |
| rx_data | input | 8 | Incoming byte |
| rx_ack | output | 1 | One-cycle acknowledge of a stored incoming byte |
| tx_syn | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ack | input | 1 | Acknowledge of the outgoing byte from the receiver |
| core_rst_n | output | 1 | Active-low reset pulse towards the core |
| core_cs | output | 1 | Core chip-select, one cycle per access |
| core_we | output | 1 | Core write-enable |
| core_addr | output | 16 | Core word address |
| core_wdata | output | 32 | Core write data |
| core_rdata | input | 32 | Core read data, sampled in the access cycle |
| core_err | input | 1 | Core error flag, sampled in the access cycle |

## Verification
The assertions assume the following about the byte links. The sender holds rx_syn until it sees rx_ack and then drops it. tx_ack is raised only in answer to tx_syn and is a single pulse, so it is low again before the next byte is presented. The stimulus keeps to this rule: the byte-send task lowers rx_syn in the cycle after it sees the acknowledge, and the reply collector raises tx_ack for exactly one cycle after a chosen delay. The core model in the bench answers reads combinationally from the address and raises core_err only while chip-select is high, which matches the single access cycle the engine uses.

// File: rtl/fce_pkg.sv
package fce_pkg;
  // Command framing
  localparam logic [7:0] CMD_OPEN  = 8'h55;
  localparam logic [7:0] CMD_CLOSE = 8'hAA;
  localparam logic [7:0] OPC_RST   = 8'h01;
  localparam logic [7:0] OPC_RD    = 8'h10;
  localparam logic [7:0] OPC_WR    = 8'h11;
  // Reply framing and status codes
  localparam logic [7:0] RSP_OPEN  = 8'hAA;
  localparam logic [7:0] RSP_CLOSE = 8'h55;
  localparam logic [7:0] STS_RD_OK = 8'h7F;
  localparam logic [7:0] STS_WR_OK = 8'h7E;
  localparam logic [7:0] STS_RS_OK = 8'h7D;
  localparam logic [7:0] STS_UNK   = 8'hFE;
  localparam logic [7:0] STS_FAIL  = 8'hFD;

  typedef enum logic [2:0] {
    C_HUNT, C_OPCODE, C_ARGS, C_CLOSE, C_ACCESS, C_CORE_RST, C_REPLY
  } ctrl_state_t;

  typedef enum logic [1:0] {T_IDLE, T_SEND, T_GAP} tx_state_t;

  // Number of argument bytes between the opcode and the closing byte
  function automatic logic [2:0] arg_bytes(input logic [7:0] op);
    case (op)
      OPC_RD:  arg_bytes = 3'd2;
      OPC_WR:  arg_bytes = 3'd6;
      default: arg_bytes = 3'd0;
    endcase
  endfunction

  // Reply length: markers and status, plus four data bytes when carrying data
  function automatic logic [2:0] reply_len(input logic with_data);
    reply_len = with_data ? 3'd7 : 3'd3;
  endfunction

  // Byte idx of a reply frame
  function automatic logic [7:0] reply_byte(input logic [2:0] idx, input logic [7:0] sts,
                                            input logic [31:0] word, input logic with_data);
    if (idx == 3'd0)                         reply_byte = RSP_OPEN;
    else if (idx == 3'd1)                    reply_byte = sts;
    else if (idx == reply_len(with_data) - 3'd1) reply_byte = RSP_CLOSE;
    else begin
      case (idx)
        3'd2:    reply_byte = word[31:24];
        3'd3:    reply_byte = word[23:16];
        3'd4:    reply_byte = word[15:8];
        default: reply_byte = word[7:0];
      endcase
    end
  endfunction
endpackage

// File: rtl/fce_rx_buf.sv
module fce_rx_buf #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_syn,
  input  logic [7:0]               rx_data,
  output logic                     rx_ack,
  input  logic                     pop,
  output logic [7:0]               head,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          wait_low;
  logic          byte_accept;
  logic          do_pop;

  assign empty       = (cnt == '0);
  assign full        = (cnt == LW'(DEPTH));
  assign level       = cnt;
  assign head        = mem[rd_ptr];
  assign byte_accept = rx_syn && !wait_low && !full;
  assign do_pop      = pop && !empty;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    next_ptr = (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      wait_low <= 1'b0;
      rx_ack   <= 1'b0;
    end else begin
      rx_ack <= byte_accept;
      if (byte_accept)  wait_low <= 1'b1;
      else if (!rx_syn) wait_low <= 1'b0;
      if (byte_accept) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)      rd_ptr <= next_ptr(rd_ptr);
      case ({byte_accept, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (byte_accept) mem[wr_ptr] <= rx_data;
  end
endmodule

// File: rtl/fce_tx_sender.sv
module fce_tx_sender
  import fce_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [7:0]  sts,
  input  logic [31:0] word,
  input  logic        with_data,
  output logic        tx_syn,
  output logic [7:0]  tx_data,
  input  logic        tx_ack,
  output logic        done
);
  tx_state_t   st;
  logic [2:0]  idx;
  logic [7:0]  sts_q;
  logic [31:0] word_q;
  logic        wd_q;
  logic        last_byte;

  assign last_byte = (idx == reply_len(wd_q) - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= T_IDLE;
      idx     <= '0;
      sts_q   <= '0;
      word_q  <= '0;
      wd_q    <= 1'b0;
      tx_syn  <= 1'b0;
      tx_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        T_IDLE: if (go) begin
          sts_q   <= sts;
          word_q  <= word;
          wd_q    <= with_data;
          idx     <= '0;
          tx_data <= reply_byte(3'd0, sts, word, with_data);
          tx_syn  <= 1'b1;
          st      <= T_SEND;
        end
        T_SEND: if (tx_ack) begin
          tx_syn <= 1'b0;
          st     <= T_GAP;
        end
        T_GAP: if (!tx_ack) begin
          if (last_byte) begin
            done <= 1'b1;
            st   <= T_IDLE;
          end else begin
            idx     <= idx + 3'd1;
            tx_data <= reply_byte(idx + 3'd1, sts_q, word_q, wd_q);
            tx_syn  <= 1'b1;
            st      <= T_SEND;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fce_ctrl.sv
module fce_ctrl
  import fce_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        buf_empty,
  input  logic [7:0]  buf_head,
  output logic        buf_pop,
  output logic        core_rst_n,
  output logic        core_cs,
  output logic        core_we,
  output logic [15:0] core_addr,
  output logic [31:0] core_wdata,
  input  logic [31:0] core_rdata,
  input  logic        core_err,
  output logic        tx_go,
  output logic [7:0]  rsp_sts,
  output logic [31:0] rsp_word,
  output logic        rsp_with_data,
  input  logic        tx_done
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  ctrl_state_t st;
  logic [7:0]  op;
  logic [2:0]  arg_cnt;
  logic [RW-1:0] rst_cnt;
  logic        parsing;
  logic        take;

  assign parsing    = (st == C_HUNT) || (st == C_OPCODE) || (st == C_ARGS) || (st == C_CLOSE);
  assign buf_pop    = parsing && !buf_empty;
  assign take       = buf_pop;
  assign core_cs    = (st == C_ACCESS);
  assign core_we    = core_cs && (op == OPC_WR);
  assign core_rst_n = (st != C_CORE_RST);

  function automatic logic known_op(input logic [7:0] b);
    known_op = (b == OPC_RST) || (b == OPC_RD) || (b == OPC_WR);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= C_HUNT;
      op            <= '0;
      arg_cnt       <= '0;
      rst_cnt       <= '0;
      core_addr     <= '0;
      core_wdata    <= '0;
      rsp_sts       <= '0;
      rsp_word      <= '0;
      rsp_with_data <= 1'b0;
      tx_go         <= 1'b0;
    end else begin
      tx_go <= 1'b0;
      case (st)
        C_HUNT: if (take && buf_head == CMD_OPEN) st <= C_OPCODE;
        C_OPCODE: if (take) begin
          if (known_op(buf_head)) begin
            op      <= buf_head;
            arg_cnt <= '0;
            st      <= (arg_bytes(buf_head) == 3'd0) ? C_CLOSE : C_ARGS;
          end else begin
            rsp_sts       <= STS_UNK;
            rsp_with_data <= 1'b0;
            tx_go         <= 1'b1;
            st            <= C_REPLY;
          end
        end
        C_ARGS: if (take) begin
          if (arg_cnt < 3'd2) core_addr  <= {core_addr[7:0], buf_head};
          else                core_wdata <= {core_wdata[23:0], buf_head};
          arg_cnt <= arg_cnt + 3'd1;
          if (arg_cnt == arg_bytes(op) - 3'd1) st <= C_CLOSE;
        end
        C_CLOSE: if (take) begin
          if (buf_head != CMD_CLOSE) begin
            rsp_sts       <= STS_FAIL;
            rsp_with_data <= 1'b0;
            tx_go         <= 1'b1;
            st            <= C_REPLY;
          end else if (op == OPC_RST) begin
            rst_cnt <= '0;
            st      <= C_CORE_RST;
          end else begin
            st <= C_ACCESS;
          end
        end
        C_ACCESS: begin
          rsp_word      <= core_rdata;
          rsp_sts       <= core_err ? STS_FAIL : ((op == OPC_WR) ? STS_WR_OK : STS_RD_OK);
          rsp_with_data <= !core_err && (op == OPC_RD);
          tx_go         <= 1'b1;
          st            <= C_REPLY;
        end
        C_CORE_RST: begin
          rst_cnt <= rst_cnt + 1'b1;
          if (rst_cnt == RW'(RST_CYCLES - 1)) begin
            rsp_sts       <= STS_RS_OK;
            rsp_with_data <= 1'b0;
            tx_go         <= 1'b1;
            st            <= C_REPLY;
          end
        end
        C_REPLY: if (tx_done) st <= C_HUNT;
        default: st <= C_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/frame_cmd_engine.sv
module frame_cmd_engine #(
  parameter int DEPTH      = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_syn,
  input  logic [7:0]  rx_data,
  output logic        rx_ack,
  output logic        tx_syn,
  output logic [7:0]  tx_data,
  input  logic        tx_ack,
  output logic        core_rst_n,
  output logic        core_cs,
  output logic        core_we,
  output logic [15:0] core_addr,
  output logic [31:0] core_wdata,
  input  logic [31:0] core_rdata,
  input  logic        core_err
);
  localparam int LW = $clog2(DEPTH + 1);

  logic          buf_pop, buf_empty, buf_full;
  logic [7:0]    buf_head;
  logic [LW-1:0] buf_level;
  logic          tx_go, tx_done, rsp_with_data;
  logic [7:0]    rsp_sts;
  logic [31:0]   rsp_word;

  fce_rx_buf #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_syn(rx_syn), .rx_data(rx_data), .rx_ack(rx_ack),
    .pop(buf_pop), .head(buf_head), .empty(buf_empty), .full(buf_full), .level(buf_level)
  );

  fce_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .buf_empty(buf_empty), .buf_head(buf_head), .buf_pop(buf_pop),
    .core_rst_n(core_rst_n), .core_cs(core_cs), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_err(core_err),
    .tx_go(tx_go), .rsp_sts(rsp_sts), .rsp_word(rsp_word), .rsp_with_data(rsp_with_data),
    .tx_done(tx_done)
  );

  fce_tx_sender u_tx (
    .clk(clk), .rst_n(rst_n), .go(tx_go), .sts(rsp_sts), .word(rsp_word),
    .with_data(rsp_with_data), .tx_syn(tx_syn), .tx_data(tx_data), .tx_ack(tx_ack),
    .done(tx_done)
  );
endmodule

// File: rtl/fce_checker.sv
module fce_checker #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_syn,
  input logic                       rx_ack,
  input logic                       tx_syn,
  input logic [7:0]                 tx_data,
  input logic                       tx_ack,
  input logic                       core_rst_n,
  input logic                       core_cs,
  input logic                       core_we,
  input logic                       buf_full,
  input logic [$clog2(DEPTH+1)-1:0] buf_level
);
  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |=> !rx_ack);
  p_ack_after_syn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |-> $past(rx_syn));
  p_no_ack_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |=> !rx_ack);
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_level <= ($clog2(DEPTH+1))'(DEPTH));
  p_rst_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> !core_cs);
  p_cs_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_cs |=> !core_cs);
  p_we_inside_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_we |-> core_cs);
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_syn && !tx_ack) |=> (tx_syn && $stable(tx_data)));
endmodule

bind frame_cmd_engine fce_checker #(.DEPTH(DEPTH)) u_fce_chk (
  .clk(clk), .rst_n(rst_n), .rx_syn(rx_syn), .rx_ack(rx_ack), .tx_syn(tx_syn),
  .tx_data(tx_data), .tx_ack(tx_ack), .core_rst_n(core_rst_n), .core_cs(core_cs),
  .core_we(core_we), .buf_full(buf_full), .buf_level(buf_level)
);

// File: tb/tb_frame_cmd_engine.sv
`timescale 1ns/1ps
module tb_frame_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_syn = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ack;
  logic        tx_syn;
  logic [7:0]  tx_data;
  logic        tx_ack = 1'b0;
  logic        core_rst_n, core_cs, core_we;
  logic [15:0] core_addr;
  logic [31:0] core_wdata;
  logic [31:0] core_rdata;
  logic        core_err;
  logic        err_mode = 1'b0;

  always #5 clk = ~clk;

  frame_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .rx_syn(rx_syn), .rx_data(rx_data), .rx_ack(rx_ack),
    .tx_syn(tx_syn), .tx_data(tx_data), .tx_ack(tx_ack), .core_rst_n(core_rst_n),
    .core_cs(core_cs), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_err(core_err)
  );

  // Core model: data derived from the address, error only while selected
  assign core_rdata = {core_addr ^ 16'hA5C3, core_addr};
  assign core_err   = err_mode & core_cs;

  int n_checks = 0, n_fails = 0;
  int cs_count = 0, rstlow_count = 0;
  logic        last_we;
  logic [15:0] last_addr;
  logic [31:0] last_wdata;
  logic [7:0]  rsp_q [0:15];
  int          rsp_n = 0;
  int          ack_delay = 2;
  bit          ended = 0;

  always @(posedge clk) begin
    if (core_cs) begin
      cs_count   = cs_count + 1;
      last_we    = core_we;
      last_addr  = core_addr;
      last_wdata = core_wdata;
    end
    if (rst_n && !core_rst_n) rstlow_count = rstlow_count + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  // Reply collector: acknowledges each byte after ack_delay cycles (R11)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_syn && !tx_ack) begin
        logic [7:0] cur;
        bit held;
        cur  = tx_data;
        held = 1;
        for (int k = 0; k < ack_delay; k++) begin
          @(negedge clk);
          if (!tx_syn || tx_data != cur) held = 0;
        end
        chk(held, "R11 byte held until ack", {56'd0, tx_data}, {56'd0, cur});
        tx_ack = 1'b1;
        if (rsp_n < 16) rsp_q[rsp_n] = cur;
        rsp_n++;
        @(negedge clk);
        tx_ack = 1'b0;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    int t;
    @(negedge clk);
    rx_syn  = 1'b1;
    rx_data = b;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!rx_ack && t < 3000);
    chk(rx_ack, "R2 byte acknowledged", {63'd0, rx_ack}, 64'd1);
    rx_syn = 1'b0;
    @(negedge clk);
    chk(!rx_ack, "R2 ack one cycle", {63'd0, rx_ack}, 64'd0);
  endtask

  function automatic logic [7:0] exp_reply(input int i, input logic [7:0] st,
                                          input logic [31:0] d, input bit wd);
    logic [7:0] bytes7 [7];
    logic [7:0] bytes3 [3];
    bytes7 = '{8'hAA, st, d[31:24], d[23:16], d[15:8], d[7:0], 8'h55};
    bytes3 = '{8'hAA, st, 8'h55};
    return wd ? bytes7[i] : bytes3[i];
  endfunction

  task automatic check_rsp(input string req, input logic [7:0] st, input logic [31:0] d, input bit wd);
    int n, t;
    n = wd ? 7 : 3;
    t = 0;
    while (rsp_n < n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (30) @(negedge clk);
    chk(rsp_n == n, {req, " reply length"}, rsp_n, n);
    for (int i = 0; i < n && i < rsp_n; i++)
      chk(rsp_q[i] == exp_reply(i, st, d, wd), {req, " reply byte"}, {56'd0, rsp_q[i]},
          {56'd0, exp_reply(i, st, d, wd)});
  endtask

  task automatic send_read(input logic [15:0] a, input logic [7:0] close);
    send_byte(8'h55); send_byte(8'h10); send_byte(a[15:8]); send_byte(a[7:0]); send_byte(close);
  endtask

  task automatic send_write(input logic [15:0] a, input logic [31:0] d);
    send_byte(8'h55); send_byte(8'h11); send_byte(a[15:8]); send_byte(a[7:0]);
    send_byte(d[31:24]); send_byte(d[23:16]); send_byte(d[15:8]); send_byte(d[7:0]);
    send_byte(8'hAA);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(!rx_ack && !tx_syn && !core_cs && !core_we && core_rst_n, "R1 reset outputs",
        {59'd0, rx_ack, tx_syn, core_cs, core_we, core_rst_n}, 64'd1);
  endtask

  task automatic t_core_reset();
    int c0;
    c0 = cs_count; rsp_n = 0; rstlow_count = 0;
    send_byte(8'h55); send_byte(8'h01); send_byte(8'hAA);
    check_rsp("R4", 8'h7D, 32'h0, 0);
    chk(rstlow_count == 4, "R4 core reset length", rstlow_count, 4);
    chk(cs_count == c0, "R4 no access", cs_count, c0);
  endtask

  task automatic t_read();
    int c0;
    c0 = cs_count; rsp_n = 0;
    send_read(16'h1234, 8'hAA);
    check_rsp("R5", 8'h7F, {16'h1234 ^ 16'hA5C3, 16'h1234}, 1);
    chk(cs_count == c0 + 1, "R5 one access", cs_count, c0 + 1);
    chk(!last_we && last_addr == 16'h1234, "R5 read address", {47'd0, last_we, last_addr}, 64'h1234);
  endtask

  task automatic t_write();
    int c0;
    c0 = cs_count; rsp_n = 0;
    send_write(16'h00AA, 32'h1337BEEF);
    check_rsp("R6", 8'h7E, 32'h0, 0);
    chk(cs_count == c0 + 1, "R6 one access", cs_count, c0 + 1);
    chk(last_we && last_addr == 16'h00AA, "R6 write address", {47'd0, last_we, last_addr}, 64'h100AA);
    chk(last_wdata == 32'h1337BEEF, "R6 write data", last_wdata, 64'h1337BEEF);
  endtask

  task automatic t_core_error();
    int c0;
    err_mode = 1'b1;
    c0 = cs_count; rsp_n = 0;
    send_read(16'h0010, 8'hAA);
    check_rsp("R7 read", 8'hFD, 32'h0, 0);
    rsp_n = 0;
    send_write(16'h0020, 32'h55AA55AA);
    check_rsp("R7 write", 8'hFD, 32'h0, 0);
    chk(cs_count == c0 + 2, "R7 accesses made", cs_count, c0 + 2);
    err_mode = 1'b0;
  endtask

  task automatic t_unknown();
    int c0;
    c0 = cs_count; rsp_n = 0;
    send_byte(8'h55); send_byte(8'h42); send_byte(8'hAA);
    check_rsp("R8", 8'hFE, 32'h0, 0);
    chk(cs_count == c0, "R8 no access", cs_count, c0);
  endtask

  task automatic t_bad_close();
    int c0;
    c0 = cs_count; rsp_n = 0;
    send_read(16'h0001, 8'h33);
    check_rsp("R9", 8'hFD, 32'h0, 0);
    chk(cs_count == c0, "R9 no access", cs_count, c0);
  endtask

  task automatic t_junk();
    int c0;
    c0 = cs_count; rsp_n = 0;
    send_byte(8'h00); send_byte(8'hAA); send_byte(8'h7F); send_byte(8'h10);
    repeat (50) @(negedge clk);
    chk(rsp_n == 0, "R10 no reply", rsp_n, 0);
    chk(cs_count == c0, "R10 no access", cs_count, c0);
    send_read(16'h0055, 8'hAA);
    check_rsp("R10 resync", 8'h7F, {16'h0055 ^ 16'hA5C3, 16'h0055}, 1);
  endtask

  task automatic t_backpressure();
    int t;
    bit quiet;
    ack_delay = 40; rsp_n = 0;
    send_read(16'h0ABC, 8'hAA);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 8; i++) send_byte(8'h00);
    @(negedge clk);
    rx_syn = 1'b1; rx_data = 8'h00;
    quiet = 1;
    repeat (10) begin
      @(negedge clk);
      if (rx_ack) quiet = 0;
    end
    chk(quiet, "R3 ack withheld while full", {63'd0, !quiet}, 64'd0);
    t = 0;
    while (!rx_ack && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(rx_ack, "R3 byte taken after drain", {63'd0, rx_ack}, 64'd1);
    rx_syn = 1'b0;
    check_rsp("R3 reply under slow ack", 8'h7F, {16'h0ABC ^ 16'hA5C3, 16'h0ABC}, 1);
    ack_delay = 2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_core_reset();
    t_read();
    t_write();
    t_core_error();
    t_unknown();
    t_bad_close();
    t_junk();
    t_backpressure();
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule